// File: doc/BRIEF.md
# Condition Flag and Branch Resolver

This block keeps the three result-sign flags of a 16-bit processor and resolves where control goes next. Each time the datapath finishes an arithmetic, logic or load step, it presents the 16-bit result together with an update strobe. On that clock edge the block records whether the result was negative, zero or positive. After every update exactly one of the three flags is set.

The rest of the block is combinational. It looks at the current instruction word, the already-incremented program counter and a base register value. From these it produces three outputs:

- a taken signal;
- the next program counter;
- the effective address of the instruction's memory operand or jump destination.

The flags are the only stored state.

A conditional branch names a three-bit selection of the flags. It is taken when any selected flag is set. An empty selection therefore never branches, and a full selection always branches. Register-indirect jumps and subroutine calls are taken without condition. All address sums wrap modulo 2^16.

The flag, result and address pins are plain control and status signals. The block has no handshake. Results are valid while the inputs are held.

Top module: `ccb_branch_unit`

## Requirements
- R1: After reset the flags read N=0, Z=1, P=0. The output `cc_flags` is ordered {N,Z,P}, with N in bit 2 and P in bit 0.
- R2: On a rising clock edge with `cc_upd` high, the flags take the sign of `wr_val` as a two's-complement number: 100 if bit 15 is set, 010 if the value is zero, and 001 otherwise. Exactly one flag is set at all times.
- R3: On an edge with `cc_upd` low, the flags keep their value whatever `wr_val` holds.
- R4: For opcode 0000 (instr[15:12]), `br_taken` is high exactly when (instr[11:9] AND `cc_flags`) is nonzero. A selection of 000 is never taken and 111 is always taken.
- R5: For opcode 0000, the destination is `pc_inc` plus instr[8:0] sign-extended, modulo 2^16. `next_pc` equals that destination when taken and `pc_inc` otherwise. `eff_addr` always carries the destination.
- R6: Opcode 1100 is always taken. `next_pc` and `eff_addr` both equal `base_val`.
- R7: Opcode 0100 is always taken. With instr[11]=1 the destination is `pc_inc` plus instr[10:0] sign-extended. With instr[11]=0 the destination is `base_val`.
- R8: For opcodes 0010, 0011, 1010, 1011 and 1110, `eff_addr` is `pc_inc` plus instr[8:0] sign-extended. These opcodes are not taken, and `next_pc` equals `pc_inc`.
- R9: For opcodes 0110 and 0111, `eff_addr` is `base_val` plus instr[5:0] sign-extended. These opcodes are not taken.
- R10: For opcode 1111, `eff_addr` is instr[7:0] zero-extended. This opcode is not taken.
- R11: Opcodes 0001, 0101, 1001, 1000 and 1101 are not taken. For these, `next_pc` equals `pc_inc` and `eff_addr` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the flag register |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr | input | 16 | Current instruction word |
| pc_inc | input | 16 | Program counter already advanced by one |
| base_val | input | 16 | Contents of the instruction's base register |
| wr_val | input | 16 | Result being written back; sets the flags |
| cc_upd | input | 1 | Flag update strobe |
| cc_flags | output | 3 | {N,Z,P} |
| br_taken | output | 1 | Control transfer taken |
| next_pc | output | 16 | Next program counter |
| eff_addr | output | 16 | Computed effective address |

## Verification
`br_taken`, `next_pc` and `eff_addr` are combinational, so they are due in the same cycle their inputs change. The bench drives the inputs on the falling edge and samples one time unit later, with no rising edge in between. A flag update passes through a single register. The bench therefore raises `cc_upd` on a falling edge and reads `cc_flags` on the next falling edge, after exactly one rising edge. The hold check reads the flags one edge after an unstrobed change of `wr_val`.

// File: rtl/ccb_pkg.sv
package ccb_pkg;
  typedef enum logic [3:0] {
    OP_BR   = 4'h0, OP_ADD = 4'h1, OP_LD   = 4'h2, OP_ST  = 4'h3,
    OP_JSR  = 4'h4, OP_AND = 4'h5, OP_LDR  = 4'h6, OP_STR = 4'h7,
    OP_RTI  = 4'h8, OP_NOT = 4'h9, OP_LDI  = 4'hA, OP_STI = 4'hB,
    OP_JMP  = 4'hC, OP_RSV = 4'hD, OP_LEA  = 4'hE, OP_TRAP = 4'hF
  } opcode_e;

  typedef struct packed {
    logic n;
    logic z;
    logic p;
  } cc_t;

  localparam cc_t CC_RESET = '{n: 1'b0, z: 1'b1, p: 1'b0};
endpackage

// File: rtl/ccb_cc_reg.sv
module ccb_cc_reg
  import ccb_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd,
  input  logic [DATA_W-1:0] result,
  output cc_t               cc
);
  localparam int SIGN_BIT = DATA_W - 1;

  cc_t cc_next;

  always_comb begin
    cc_next.n = result[SIGN_BIT];
    cc_next.z = (result == '0);
    cc_next.p = !result[SIGN_BIT] && (result != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cc <= CC_RESET;
    else if (upd) cc <= cc_next;
  end

  AST_CC_RESET_VAL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (cc == CC_RESET)); // R1
  AST_CC_ONE_HOT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(cc) == 1); // R2
  AST_CC_NEG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && result[SIGN_BIT]) |=> cc.n); // R2
  AST_CC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !upd |=> $stable(cc)); // R3
endmodule

// File: rtl/ccb_addr_gen.sv
module ccb_addr_gen
  import ccb_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int OFF_S_W = 6,
  parameter int OFF_M_W = 9,
  parameter int OFF_L_W = 11,
  parameter int VEC_W = 8
) (
  input  logic [DATA_W-1:0] instr,
  input  logic [DATA_W-1:0] pc_inc,
  input  logic [DATA_W-1:0] base_val,
  output logic [DATA_W-1:0] ea
);
  localparam int OP_LSB = DATA_W - 4;
  localparam int LINK_BIT = OFF_L_W;

  logic [DATA_W-1:0] off_s, off_m, off_l, vec_z;
  opcode_e op;

  assign op    = opcode_e'(instr[DATA_W-1:OP_LSB]);
  assign off_s = {{(DATA_W-OFF_S_W){instr[OFF_S_W-1]}}, instr[OFF_S_W-1:0]};
  assign off_m = {{(DATA_W-OFF_M_W){instr[OFF_M_W-1]}}, instr[OFF_M_W-1:0]};
  assign off_l = {{(DATA_W-OFF_L_W){instr[OFF_L_W-1]}}, instr[OFF_L_W-1:0]};
  assign vec_z = {{(DATA_W-VEC_W){1'b0}}, instr[VEC_W-1:0]};

  always_comb begin
    unique case (op)
      OP_BR, OP_LD, OP_ST, OP_LDI, OP_STI, OP_LEA: ea = pc_inc + off_m;
      OP_JSR:           ea = instr[LINK_BIT] ? (pc_inc + off_l) : base_val;
      OP_LDR, OP_STR:   ea = base_val + off_s;
      OP_JMP:           ea = base_val;
      OP_TRAP:          ea = vec_z;
      default:          ea = '0;
    endcase
  end
endmodule

// File: rtl/ccb_branch_dec.sv
module ccb_branch_dec
  import ccb_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] instr,
  input  cc_t               cc,
  output logic              taken
);
  localparam int OP_LSB = DATA_W - 4;
  localparam int MASK_HI = OP_LSB - 1;
  localparam int MASK_LO = OP_LSB - 3;

  logic [2:0] sel;
  opcode_e op;

  assign op  = opcode_e'(instr[DATA_W-1:OP_LSB]);
  assign sel = instr[MASK_HI:MASK_LO];

  always_comb begin
    unique case (op)
      OP_BR:          taken = |(sel & cc);
      OP_JMP, OP_JSR: taken = 1'b1;
      default:        taken = 1'b0;
    endcase
  end
endmodule

// File: rtl/ccb_branch_unit.sv
module ccb_branch_unit
  import ccb_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] instr,
  input  logic [DATA_W-1:0] pc_inc,
  input  logic [DATA_W-1:0] base_val,
  input  logic [DATA_W-1:0] wr_val,
  input  logic              cc_upd,
  output logic [2:0]        cc_flags,
  output logic              br_taken,
  output logic [DATA_W-1:0] next_pc,
  output logic [DATA_W-1:0] eff_addr
);
  localparam int OP_LSB = DATA_W - 4;

  cc_t cc;

  ccb_cc_reg #(.DATA_W(DATA_W)) u_cc (
    .clk(clk), .rst_n(rst_n), .upd(cc_upd), .result(wr_val), .cc(cc)
  );

  ccb_branch_dec #(.DATA_W(DATA_W)) u_dec (
    .instr(instr), .cc(cc), .taken(br_taken)
  );

  ccb_addr_gen #(.DATA_W(DATA_W)) u_ag (
    .instr(instr), .pc_inc(pc_inc), .base_val(base_val), .ea(eff_addr)
  );

  assign cc_flags = cc;
  assign next_pc  = br_taken ? eff_addr : pc_inc;

  AST_BR_EMPTY_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    (instr[DATA_W-1:OP_LSB] == 4'h0 && instr[OP_LSB-1:OP_LSB-3] == 3'b000)
      |-> !br_taken); // R4
  AST_BR_FULL_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    (instr[DATA_W-1:OP_LSB] == 4'h0 && instr[OP_LSB-1:OP_LSB-3] == 3'b111)
      |-> br_taken); // R4
  AST_JMP_TO_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    (instr[DATA_W-1:OP_LSB] == 4'hC) |-> (br_taken && next_pc == base_val)); // R6
  AST_ALU_NO_JUMP: assert property (@(posedge clk) disable iff (!rst_n)
    (instr[DATA_W-1:OP_LSB] == 4'h1) |-> (!br_taken && next_pc == pc_inc)); // R11
endmodule

// File: tb/tb_ccb_branch_unit.sv
module tb_ccb_branch_unit;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] instr = '0, pc_inc = '0, base_val = '0, wr_val = '0;
  logic cc_upd = 1'b0;
  logic [2:0] cc_flags;
  logic br_taken;
  logic [15:0] next_pc, eff_addr;

  int n_checks = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ccb_branch_unit dut (
    .clk(clk), .rst_n(rst_n), .instr(instr), .pc_inc(pc_inc),
    .base_val(base_val), .wr_val(wr_val), .cc_upd(cc_upd),
    .cc_flags(cc_flags), .br_taken(br_taken), .next_pc(next_pc),
    .eff_addr(eff_addr)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h instr=%h", req, act, exp, instr);
    end
  endtask

  function automatic logic [2:0] sign_of(input logic [15:0] v);
    if ($signed(v) < 0) return 3'b100;
    if (v == 16'd0)     return 3'b010;
    return 3'b001;
  endfunction

  function automatic int sx(input logic [15:0] ir, input int bits);
    int u = int'(ir) & ((1 << bits) - 1);
    if (u >= (1 << (bits - 1))) u = u - (1 << bits);
    return u;
  endfunction

  function automatic logic [15:0] wrap(input int v);
    return 16'(v & 32'hFFFF);
  endfunction

  function automatic logic [15:0] model_ea(input logic [15:0] ir, input logic [15:0] pc,
                                          input logic [15:0] b);
    case (ir[15:12])
      4'h0, 4'h2, 4'h3, 4'hA, 4'hB, 4'hE: return wrap(int'(pc) + sx(ir, 9));
      4'h4: return ir[11] ? wrap(int'(pc) + sx(ir, 11)) : b;
      4'h6, 4'h7: return wrap(int'(b) + sx(ir, 6));
      4'hC: return b;
      4'hF: return {8'h00, ir[7:0]};
      default: return 16'h0000;
    endcase
  endfunction

  function automatic logic model_taken(input logic [15:0] ir, input logic [2:0] f);
    if (ir[15:12] == 4'h0) return (ir[11:9] & f) != 3'b000;
    return ir[15:12] == 4'hC || ir[15:12] == 4'h4;
  endfunction

  function automatic string req_of(input logic [3:0] op);
    case (op)
      4'h0: return "R5";
      4'hC: return "R6";
      4'h4: return "R7";
      4'h2, 4'h3, 4'hA, 4'hB, 4'hE: return "R8";
      4'h6, 4'h7: return "R9";
      4'hF: return "R10";
      default: return "R11";
    endcase
  endfunction

  // One strobed edge between falling edges; flags due one edge later.
  task automatic load_flags(input logic [15:0] v);
    @(negedge clk);
    wr_val = v;
    cc_upd = 1'b1;
    @(negedge clk);
    cc_upd = 1'b0;
    #1;
    chk("R2 flags", {13'd0, cc_flags}, {13'd0, sign_of(v)});
    wr_val = ~v + 16'd1;
    @(negedge clk);
    #1;
    chk("R3 hold", {13'd0, cc_flags}, {13'd0, sign_of(v)});
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    logic [15:0] vals[5] = '{16'h0000, 16'h0001, 16'h7FFF, 16'h8000, 16'hFFFF};
    logic [15:0] fvals[3] = '{16'hFFFB, 16'h0000, 16'h0007};
    logic [8:0]  offs[4] = '{9'h000, 9'h0FF, 9'h100, 9'h1FF};
    logic [15:0] pcs[2] = '{16'h3005, 16'hFFF0};
    logic [11:0] lows[6] = '{12'h000, 12'hFFF, 12'h83F, 12'h7C0, 12'h1A5, 12'h820};
    logic [15:0] bases[2] = '{16'h8001, 16'hFFFE};

    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 reset flags", {13'd0, cc_flags}, 16'h0002);

    // R4 before any update: Z only, so selection 010 taken and 101 not.
    instr = {4'h0, 3'b010, 9'h004};
    pc_inc = 16'h3000;
    #1;
    chk("R4 reset z sel", {15'd0, br_taken}, 16'h0001);
    instr = {4'h0, 3'b101, 9'h004};
    #1;
    chk("R4 reset np sel", {15'd0, br_taken}, 16'h0000);

    foreach (vals[i]) load_flags(vals[i]);
    for (int k = 0; k < 20; k++) load_flags(16'(k * 16'h0CCD));

    // Conditional branch sweep over flag state, selection, offset and PC.
    foreach (fvals[fi]) begin
      load_flags(fvals[fi]);
      for (int m = 0; m < 8; m++) begin
        foreach (offs[oi]) begin
          foreach (pcs[pi]) begin
            @(negedge clk);
            instr = {4'h0, 3'(m), offs[oi]};
            pc_inc = pcs[pi];
            base_val = 16'h1234;
            #1;
            chk("R4 taken", {15'd0, br_taken},
                {15'd0, model_taken(instr, sign_of(fvals[fi]))});
            chk("R5 next pc", next_pc,
                model_taken(instr, sign_of(fvals[fi])) ? model_ea(instr, pc_inc, base_val)
                                                       : pc_inc);
            chk("R5 dest", eff_addr, model_ea(instr, pc_inc, base_val));
          end
        end
      end
    end

    // Every opcode against several field patterns, bases and PCs; flags are P.
    for (int op = 0; op < 16; op++) begin
      foreach (lows[li]) begin
        foreach (bases[bi]) begin
          foreach (pcs[pi]) begin
            @(negedge clk);
            instr = {4'(op), lows[li]};
            base_val = bases[bi];
            pc_inc = pcs[pi];
            #1;
            chk(req_of(4'(op)), {15'd0, br_taken},
                {15'd0, model_taken(instr, 3'b001)});
            chk(req_of(4'(op)), next_pc,
                model_taken(instr, 3'b001) ? model_ea(instr, pc_inc, base_val) : pc_inc);
            chk(req_of(4'(op)), eff_addr, model_ea(instr, pc_inc, base_val));
          end
        end
      end
    end

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule